// File: doc/BRIEF.md
# Wiper Register Command Decoder

This block sits behind a two-wire serial slave that has already turned the line activity into bytes and start/stop events. It interprets the command bytes that control a digitally set resistor with 1024 tap positions. Each transaction opens with an identification byte. That byte must carry a fixed device-type nibble and a three-bit address that agrees with the strapping pins; otherwise the transaction is ignored and every byte is left unacknowledged.

After a matching identification, an instruction byte names one of six operations. Two operations read or write the live wiper register. Two read or write one of four stored data registers. The last two copy a value between the wiper register and a stored register, in either direction. Ten-bit values move as two bytes with the high byte first. The wiper register drives the tap position output directly. Read bytes go back to the serial front end one per request.

Top module: `wiper_cmd_ctrl`

## Requirements
- R1: After a start event, the first byte must have bits [7:4] equal to 4'b0101. Otherwise ack is 0 for that byte and for every later byte up to the next start, and no register changes.
- R2: Identification bits [3:1] must equal addr_pins. A mismatch is handled exactly as in R1.
- R3: Identification bit 0 is the direction bit. Read opcodes need it set to 1, and all other opcodes need it set to 0. If the direction bit disagrees with the opcode, the instruction byte gets ack 0 and has no effect.
- R4: In the instruction byte, bits [7:5] are the opcode and bits [3:2] select data register 0 to 3. Bits 4, 1 and 0 are ignored.
- R5: Opcode 3'b101 writes the wiper register. It takes two data bytes, high byte first. Only bits [1:0] of the high byte are used. wiper_pos changes on the clock edge that accepts the second byte.
- R6: Opcode 3'b111 writes the selected data register from two data bytes, using the same byte format as R5.
- R7: Opcode 3'b100 reads the wiper register. The first rd_req returns the high byte with bits [7:2] zero, and the second returns the low byte. rd_valid pulses, and rd_data holds the byte, in the cycle after each request.
- R8: Opcode 3'b110 reads the selected data register in the same format as R7.
- R9: Opcode 3'b011 copies the selected data register into the wiper register on the instruction byte, with no data bytes.
- R10: Opcode 3'b010 copies the wiper register into the selected data register on the instruction byte.
- R11: Opcodes 3'b000 and 3'b001 get ack 0 and change no register.
- R12: A stop event before the second data byte of a write throws away the partial value, and the target register is left unchanged.
- R13: Reset sets all four data registers to 512. The wiper register takes the reset value of data register 0, which is also 512.
- R14: ack is registered. It shows the decision for a byte in the cycle after byte_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_pins | input | 3 | Strapped slave address |
| start | input | 1 | Start or repeated-start event pulse |
| stop | input | 1 | Stop event pulse |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| rd_req | input | 1 | Front end requests the next outgoing byte |
| ack | output | 1 | Acknowledge decision for the last received byte |
| rd_data | output | 8 | Outgoing read byte |
| rd_valid | output | 1 | rd_data updated this cycle |
| wiper_pos | output | 10 | Current wiper tap position |

## Verification
The hardest case to reach from the ports is a transfer between the wiper and a stored register whose effect shows on the ports. A copy from wiper to a data register changes nothing at wiper_pos. The stimulus therefore first overwrites the wiper with a different value, then copies the stored register back, or reads it out through the read path. Early stops and direction mismatches are placed just before such visible checks, so that a partial or rejected write would show up as a wrong tap position.

// File: rtl/wiper_ctl_pkg.sv
// Shared constants and types for the wiper command decoder.
// Assumes byte-granular input from a serial front end.
package wiper_ctl_pkg;
    localparam int NUM_DR = 4;
    localparam int SEL_W  = $clog2(NUM_DR);

    localparam logic [2:0] OP_XFER_W2D = 3'b010;
    localparam logic [2:0] OP_XFER_D2W = 3'b011;
    localparam logic [2:0] OP_RD_WCR   = 3'b100;
    localparam logic [2:0] OP_WR_WCR   = 3'b101;
    localparam logic [2:0] OP_RD_DR    = 3'b110;
    localparam logic [2:0] OP_WR_DR    = 3'b111;

    typedef enum logic [2:0] {
        S_IDLE, S_ID, S_INS, S_WHI, S_WLO, S_RD, S_SKIP
    } cmd_state_t;
endpackage

// File: rtl/wiper_id_match.sv
// Compares an identification byte with the fixed type nibble and the
// strapped address pins. Purely combinational; the caller decides when
// the byte is an identification byte.
module wiper_id_match #(
    parameter logic [3:0] TYPE_CODE = 4'b0101
) (
    input  logic [7:0] id_byte,
    input  logic [2:0] pins,
    output logic       hit,
    output logic       rd_dir
);
    // Type nibble and address field must both agree.
    always_comb begin
        hit    = (id_byte[7:4] == TYPE_CODE) && (id_byte[3:1] == pins);
        rd_dir = id_byte[0];
    end
endmodule

// File: rtl/wiper_reg_bank.sv
// Holds the live wiper register and the stored data registers, and
// applies writes and transfers. Assumes at most one strobe per cycle.
module wiper_reg_bank
    import wiper_ctl_pkg::*;
#(
    parameter int VAL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_wcr,
    input  logic             wr_dr,
    input  logic             xfer_d2w,
    input  logic             xfer_w2d,
    input  logic [SEL_W-1:0] sel,
    input  logic [VAL_W-1:0] wdata,
    output logic [VAL_W-1:0] wcr,
    output logic [VAL_W-1:0] dr_sel
);
    localparam logic [VAL_W-1:0] RESET_VAL = VAL_W'(1) << (VAL_W - 1);

    logic [VAL_W-1:0] wcr_q;
    logic [VAL_W-1:0] dr_q [NUM_DR];

    // Wiper register: reset to the data register 0 reset value, then write or copy in.
    always_ff @(posedge clk) begin
        if (!rst_n)        wcr_q <= RESET_VAL;
        else if (wr_wcr)   wcr_q <= wdata;
        else if (xfer_d2w) wcr_q <= dr_q[sel];
    end

    // Stored registers: reset to mid-scale, then write or copy from the wiper.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_DR; i++) begin
            if (!rst_n)
                dr_q[i] <= RESET_VAL;
            else if (sel == SEL_W'(i) && wr_dr)
                dr_q[i] <= wdata;
            else if (sel == SEL_W'(i) && xfer_w2d)
                dr_q[i] <= wcr_q;
        end
    end

    // Expose the live wiper and the currently selected stored register.
    always_comb begin
        wcr    = wcr_q;
        dr_sel = dr_q[sel];
    end

    a_r9_xfer_to_wiper: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_d2w |=> wcr_q == $past(dr_q[sel]));
    a_r10_xfer_to_store: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_w2d |=> dr_q[$past(sel)] == $past(wcr_q));
    a_r11_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_wcr || xfer_d2w) |=> $stable(wcr_q));
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_wcr, wr_dr, xfer_d2w, xfer_w2d}));
endmodule

// File: rtl/wiper_cmd_fsm.sv
// Walks each transaction byte by byte: identification, instruction,
// data or read-back. Emits one-cycle strobes to the register bank and a
// registered ack per byte. start and stop take priority over byte_valid.
module wiper_cmd_fsm
    import wiper_ctl_pkg::*;
#(
    parameter int VAL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             rd_req,
    input  logic             id_hit,
    input  logic             id_rd,
    input  logic [VAL_W-1:0] wcr,
    input  logic [VAL_W-1:0] dr_sel,
    output logic             ack,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             wr_wcr,
    output logic             wr_dr,
    output logic             xfer_d2w,
    output logic             xfer_w2d,
    output logic [SEL_W-1:0] sel,
    output logic [VAL_W-1:0] wdata
);
    localparam int HI_W = VAL_W - 8;

    cmd_state_t       state;
    logic             rw_q;
    logic             tgt_wcr_q;
    logic [SEL_W-1:0] sel_q;
    logic [HI_W-1:0]  hi_q;
    logic [1:0]       rd_cnt;

    logic       ev;
    logic [2:0] op;
    logic       is_read;
    logic       ins_take;
    logic       commit;
    logic [VAL_W-1:0] rd_val;

    // Decode the current byte and form the register strobes.
    always_comb begin
        ev       = byte_valid && !start && !stop;
        op       = byte_data[7:5];
        is_read  = (op == OP_RD_WCR) || (op == OP_RD_DR);
        ins_take = ev && (state == S_INS) && (op[2] || op[1]) && (is_read == rw_q);
        commit   = ev && (state == S_WLO);
        xfer_d2w = ins_take && (op == OP_XFER_D2W);
        xfer_w2d = ins_take && (op == OP_XFER_W2D);
        wr_wcr   = commit && tgt_wcr_q;
        wr_dr    = commit && !tgt_wcr_q;
        sel      = (state == S_INS) ? byte_data[3:2] : sel_q;
        wdata    = {hi_q, byte_data};
        rd_val   = tgt_wcr_q ? wcr : dr_sel;
    end

    // Transaction sequencing, per-byte ack and field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            ack       <= 1'b0;
            rw_q      <= 1'b0;
            tgt_wcr_q <= 1'b0;
            sel_q     <= '0;
            hi_q      <= '0;
        end else if (start) begin
            state <= S_ID;
        end else if (stop) begin
            state <= S_IDLE;
        end else if (ev) begin
            ack <= 1'b0;
            unique case (state)
                S_ID: begin
                    ack   <= id_hit;
                    rw_q  <= id_rd;
                    state <= id_hit ? S_INS : S_SKIP;
                end
                S_INS: begin
                    ack       <= ins_take;
                    sel_q     <= byte_data[3:2];
                    tgt_wcr_q <= (op == OP_RD_WCR) || (op == OP_WR_WCR);
                    if (!ins_take)                                state <= S_SKIP;
                    else if (op == OP_WR_WCR || op == OP_WR_DR)   state <= S_WHI;
                    else if (is_read)                             state <= S_RD;
                    else                                          state <= S_SKIP;
                end
                S_WHI: begin
                    ack   <= 1'b1;
                    hi_q  <= byte_data[HI_W-1:0];
                    state <= S_WLO;
                end
                S_WLO: begin
                    ack   <= 1'b1;
                    state <= S_SKIP;
                end
                default: ;
            endcase
        end
    end

    // Read-back: high byte first, then low byte, zero afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (state != S_RD) begin
                rd_cnt <= '0;
            end else if (rd_req) begin
                rd_valid <= 1'b1;
                if (rd_cnt == 2'd0)      rd_data <= 8'(rd_val >> 8);
                else if (rd_cnt == 2'd1) rd_data <= rd_val[7:0];
                else                     rd_data <= '0;
                if (rd_cnt != 2'd2) rd_cnt <= rd_cnt + 2'd1;
            end
        end
    end

    a_r1_id_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ID && ev) |=> ack == $past(id_hit));
    a_r2_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP && ev) |=> !ack);
    a_r12_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !(wr_wcr || wr_dr || xfer_d2w || xfer_w2d));
    a_r7_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));
endmodule

// File: rtl/wiper_cmd_ctrl.sv
// Top of the wiper command decoder: address match, command sequencing
// and register storage. Assumes a front end that delivers one byte per
// byte_valid strobe and reports start/stop as single-cycle pulses.
module wiper_cmd_ctrl #(
    parameter logic [3:0] TYPE_CODE = 4'b0101,
    parameter int         VAL_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr_pins,
    input  logic             start,
    input  logic             stop,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             rd_req,
    output logic             ack,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic [VAL_W-1:0] wiper_pos
);
    import wiper_ctl_pkg::*;

    logic             id_hit, id_rd;
    logic             wr_wcr, wr_dr, xfer_d2w, xfer_w2d;
    logic [SEL_W-1:0] sel;
    logic [VAL_W-1:0] wdata, wcr, dr_sel;

    wiper_id_match #(.TYPE_CODE(TYPE_CODE)) id_i (
        .id_byte(byte_data), .pins(addr_pins), .hit(id_hit), .rd_dir(id_rd)
    );

    wiper_cmd_fsm #(.VAL_W(VAL_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .byte_valid(byte_valid), .byte_data(byte_data), .rd_req(rd_req),
        .id_hit(id_hit), .id_rd(id_rd), .wcr(wcr), .dr_sel(dr_sel),
        .ack(ack), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_wcr(wr_wcr), .wr_dr(wr_dr), .xfer_d2w(xfer_d2w), .xfer_w2d(xfer_w2d),
        .sel(sel), .wdata(wdata)
    );

    wiper_reg_bank #(.VAL_W(VAL_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_wcr(wr_wcr), .wr_dr(wr_dr),
        .xfer_d2w(xfer_d2w), .xfer_w2d(xfer_w2d), .sel(sel), .wdata(wdata),
        .wcr(wcr), .dr_sel(dr_sel)
    );

    // The tap position is the live wiper register.
    always_comb wiper_pos = wcr;

    a_r5_tap_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_wcr |=> wiper_pos == $past(wdata));
endmodule

// File: tb/wiper_cmd_ctrl_tb_top.sv
// Bench: a vector table of write/transfer transactions, then directed
// reads, early stop and reset cases. Inputs change on the falling edge.
module wiper_cmd_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr_pins = 3'b101;
    logic       start = 1'b0, stop = 1'b0, byte_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] byte_data = '0;
    logic       ack, rd_valid;
    logic [7:0] rd_data;
    logic [9:0] wiper_pos;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    wiper_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .start(start),
        .stop(stop), .byte_valid(byte_valid), .byte_data(byte_data),
        .rd_req(rd_req), .ack(ack), .rd_data(rd_data), .rd_valid(rd_valid),
        .wiper_pos(wiper_pos)
    );

    typedef struct packed {
        logic [7:0] id;
        logic [7:0] ins;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [1:0] nb;
        logic       ack_id;
        logic       ack_ins;
        logic [9:0] wp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{8'h5A, 8'hA0, 8'hFF, 8'hFF, 2'd3, 1'b1, 1'b1, 10'd1023}, // R5 high bits ignored
        '{8'h5A, 8'hE8, 8'h00, 8'h64, 2'd3, 1'b1, 1'b1, 10'd1023}, // R6 DR2=100
        '{8'h5A, 8'h68, 8'h00, 8'h00, 2'd1, 1'b1, 1'b1, 10'd100},  // R9 DR2->wiper
        '{8'h5A, 8'hA0, 8'h00, 8'h05, 2'd3, 1'b1, 1'b1, 10'd5},    // R5
        '{8'h5A, 8'h44, 8'h00, 8'h00, 2'd1, 1'b1, 1'b1, 10'd5},    // R10 wiper->DR1
        '{8'h5A, 8'hA0, 8'h02, 8'hAA, 2'd3, 1'b1, 1'b1, 10'd682},  // R5
        '{8'h5A, 8'h64, 8'h00, 8'h00, 2'd1, 1'b1, 1'b1, 10'd5},    // R10 DR1 holds 5
        '{8'h7A, 8'hA0, 8'h00, 8'h00, 2'd3, 1'b0, 1'b0, 10'd5},    // R1 wrong type
        '{8'h58, 8'hA0, 8'h00, 8'h00, 2'd3, 1'b0, 1'b0, 10'd5},    // R2 wrong pins
        '{8'h5A, 8'h20, 8'h00, 8'h00, 2'd1, 1'b1, 1'b0, 10'd5},    // R11 opcode 001
        '{8'h5A, 8'h60, 8'h00, 8'h00, 2'd1, 1'b1, 1'b1, 10'd512},  // R13 DR0 reset value
        '{8'h5B, 8'hA0, 8'h00, 8'h07, 2'd3, 1'b1, 1'b0, 10'd512},  // R3 direction mismatch
        '{8'h5A, 8'hBF, 8'h01, 8'h23, 2'd3, 1'b1, 1'b1, 10'd291}   // R4 spare bits ignored
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
    endtask

    // Sends a byte; ack is valid on return (R14).
    task automatic send(input logic [7:0] b);
        @(negedge clk) begin byte_valid = 1'b1; byte_data = b; end
        @(negedge clk) byte_valid = 1'b0;
    endtask

    task automatic read_byte(input string req, input logic [7:0] exp);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        check({req, " rd_valid"}, 16'(rd_valid), 16'd1);
        check({req, " rd_data"}, 16'(rd_data), 16'(exp));
    endtask

    task automatic read_reg(input string req, input logic [7:0] ins,
                            input logic [7:0] e_hi, input logic [7:0] e_lo);
        ev_start();
        send(8'h5B);
        send(ins);
        check({req, " ack"}, 16'(ack), 16'd1);
        read_byte(req, e_hi);
        read_byte(req, e_lo);
        ev_stop();
    endtask

    // Watchdog: counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 reset wiper", 16'(wiper_pos), 16'd512);
        check("R14 reset ack", 16'(ack), 16'd0);

        for (int i = 0; i < NV; i++) begin
            ev_start();
            send(VEC[i].id);
            check($sformatf("R1/R2 vec%0d id ack", i), 16'(VEC[i].ack_id), 16'(ack));
            send(VEC[i].ins);
            check($sformatf("R3/R4 vec%0d ins ack", i), 16'(ack), 16'(VEC[i].ack_ins));
            if (VEC[i].nb == 2'd3) begin
                send(VEC[i].hi);
                send(VEC[i].lo);
            end
            ev_stop();
            check($sformatf("R5/R9 vec%0d wiper", i), 16'(wiper_pos), 16'(VEC[i].wp));
        end

        read_reg("R7 wiper", 8'h80, 8'h01, 8'h23);
        read_reg("R8 DR2", 8'hC8, 8'h00, 8'h64);
        read_reg("R8 DR1", 8'hC4, 8'h00, 8'h05);

        // R12: stop after only the high byte
        ev_start();
        send(8'h5A);
        send(8'hA0);
        send(8'h03);
        ev_stop();
        check("R12 early stop wiper", 16'(wiper_pos), 16'd291);
        ev_start();
        send(8'h5A);
        send(8'hE0);
        send(8'h00);
        ev_stop();
        read_reg("R12 DR0 kept", 8'hC0, 8'h02, 8'h00);

        // R13: reset in the middle of operation
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 wiper after reset", 16'(wiper_pos), 16'd512);
        read_reg("R13 DR2 after reset", 8'hC8, 8'h02, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule